// File: doc/BRIEF.md
# Dithered NCO Phase Generator

This block is the front end of a numerically controlled oscillator. It holds a 32-bit phase accumulator that grows by an unsigned tuning increment on every enabled sample clock. A one-cycle phase-offset pulse can be added into the accumulator at any moment to move the waveform's phase permanently. The upper 16 bits of the phase, optionally perturbed by pseudo-random dither from a free-running 32-bit LFSR, form the address handed to a downstream sine/cosine table, which is not part of this block.

Two waveforms come straight from the undithered phase: a sawtooth, which is the upper 16 bits of the accumulator, and a square wave at full positive or full negative scale, chosen by the phase's top bit. All three outputs leave a five-register pipeline. A clock enable freezes every stage and the LFSR together, so a stall only pauses the stream and never changes it.

Top module: `nco_phase_gen`

## Requirements
- R1: Each enabled clock adds the increment to the 32-bit accumulator modulo 2^32. When the increment I is held from reset, `sawOut` after the n-th enabled edge (n >= 5) equals the upper 16 bits of ((n-4)*I mod 2^32).
- R2: An increment value present at one enabled edge first changes the step between successive `sawOut` samples four enabled edges later, so it reaches the outputs on the fifth edge. After reset `sawOut` is still 0x0000 after the fourth edge.
- R3: `rstN` low clears every output to 0x0000 at once, with no clock edge needed.
- R4: A nonzero `phaseShift` value held for one enabled edge is added to the accumulator exactly once. The sawtooth step that carries it is the increment plus the shift, and every later step is the plain increment.
- R5: `squOut` is 0x7FFF when bit 15 of the sawtooth sample is 0 and 0x8000 when it is 1.
- R6: `phaseAddr` is the upper 16 bits of the phase plus dither. With dithering disabled (`DITHER_EN`=0) it equals `sawOut` on every cycle.
- R7: With `DITHER_EN`=1, the low 16 bits of an LFSR for x^32+x^7+x^5+x^3+x^2+x+1 (seed `SEED`, nonzero) are added below the address bits. `phaseAddr - sawOut` (mod 2^16) is therefore 0 or 1, and `sawOut` and `squOut` are the same as with dithering off. The LFSR shifts in one bit per enabled clock and is never zero.
- R8: While `en` is low, all outputs and the LFSR hold, and a `phaseShift` pulse is ignored. After `en` returns high, the next sawtooth step is the ordinary increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Clock enable; low stalls the whole pipeline |
| phaseInc | input | 32 | Unsigned tuning increment |
| phaseShift | input | 32 | One-cycle unsigned phase offset, otherwise zero |
| phaseAddr | output | 16 | Quantized (optionally dithered) phase for the lookup table |
| sawOut | output | 16 | Sawtooth sample, signed 16-bit |
| squOut | output | 16 | Square sample, 0x7FFF or 0x8000 |

## Verification
The bench builds two copies side by side on the same inputs. One has dithering off, which makes `phaseAddr` an exact, predictable value, so the accumulator sums, the wrap, the pipeline delay and the one-shot offset can all be checked against computed constants. The other has dithering on with a nonzero seed. With an increment of 0x00008000, the low phase bits sit at the carry threshold every other sample, so the dither carry occurs on some samples and not on others. That lets the bench check the 0-or-1 address bound, check that the carry occurs but not always, and check that the sawtooth matches the undithered copy.

// File: rtl/nco_pkg.sv
package nco_pkg;
  typedef struct packed {
    logic advance;
    logic ditherOn;
  } nco_strobe_t;
endpackage

// File: rtl/nco_ctrl.sv
module nco_ctrl #(
  parameter bit DITHER_EN = 1'b0
) (
  input  logic                 en,
  output nco_pkg::nco_strobe_t strb,
  output logic                 lfsrStep
);
  always_comb begin
    strb.advance  = en;
    strb.ditherOn = DITHER_EN;
    lfsrStep      = en;
  end
endmodule

// File: rtl/nco_lfsr.sv
module nco_lfsr #(
  parameter int          LFSR_W   = 32,
  parameter logic [31:0] SEED     = 32'h0000_0001,
  parameter logic [31:0] TAP_MASK = 32'h8000_0057
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              step,
  output logic [LFSR_W-1:0] state
);
  logic feedback;

  always_comb feedback = ^(state & TAP_MASK[LFSR_W-1:0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     state <= SEED[LFSR_W-1:0];
    else if (step) state <= {state[LFSR_W-2:0], feedback};
  end
endmodule

// File: rtl/nco_datapath.sv
module nco_datapath #(
  parameter int ACC_W  = 32,
  parameter int ADDR_W = 16,
  parameter int OUT_W  = 16,
  parameter int DITH_W = ACC_W - ADDR_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  nco_pkg::nco_strobe_t strb,
  input  logic [ACC_W-1:0]     phaseInc,
  input  logic [ACC_W-1:0]     phaseShift,
  input  logic [DITH_W-1:0]    ditherBits,
  output logic [ADDR_W-1:0]    phaseAddr,
  output logic [OUT_W-1:0]     sawOut,
  output logic [OUT_W-1:0]     squOut
);
  localparam logic [OUT_W-1:0] SQU_HI = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] SQU_LO = {1'b1, {(OUT_W-1){1'b0}}};

  logic [ACC_W-1:0]  incQ, shiftQ, accQ, sumQ, accDlyQ, ditherWord;
  logic [ADDR_W-1:0] addrQ;
  logic [OUT_W-1:0]  sawQ, squQ;

  generate
    if (DITH_W < ACC_W) begin : g_pad
      always_comb ditherWord = {{(ACC_W-DITH_W){1'b0}},
                                ditherBits & {DITH_W{strb.ditherOn}}};
    end else begin : g_full
      always_comb ditherWord = ditherBits & {DITH_W{strb.ditherOn}};
    end
  endgenerate

  // stage 1: capture increment and one-shot shift
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      incQ   <= '0;
      shiftQ <= '0;
    end else if (strb.advance) begin
      incQ   <= phaseInc;
      shiftQ <= phaseShift;
    end
  end

  // stage 2: accumulate
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             accQ <= '0;
    else if (strb.advance) accQ <= accQ + incQ + shiftQ;
  end

  // stage 3: dither the address path, delay the clean phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumQ    <= '0;
      accDlyQ <= '0;
    end else if (strb.advance) begin
      sumQ    <= accQ + ditherWord;
      accDlyQ <= accQ;
    end
  end

  // stage 4: quantize and shape
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      sawQ  <= '0;
      squQ  <= '0;
    end else if (strb.advance) begin
      addrQ <= sumQ[ACC_W-1 -: ADDR_W];
      sawQ  <= accDlyQ[ACC_W-1 -: OUT_W];
      squQ  <= accDlyQ[ACC_W-1] ? SQU_LO : SQU_HI;
    end
  end

  // stage 5: output registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseAddr <= '0;
      sawOut    <= '0;
      squOut    <= '0;
    end else if (strb.advance) begin
      phaseAddr <= addrQ;
      sawOut    <= sawQ;
      squOut    <= squQ;
    end
  end
endmodule

// File: rtl/nco_phase_gen.sv
module nco_phase_gen #(
  parameter int          ACC_W     = 32,
  parameter int          ADDR_W    = 16,
  parameter int          OUT_W     = 16,
  parameter bit          DITHER_EN = 1'b0,
  parameter logic [31:0] SEED      = 32'h0000_0001
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              en,
  input  logic [ACC_W-1:0]  phaseInc,
  input  logic [ACC_W-1:0]  phaseShift,
  output logic [ADDR_W-1:0] phaseAddr,
  output logic [OUT_W-1:0]  sawOut,
  output logic [OUT_W-1:0]  squOut
);
  localparam int LFSR_W = 32;
  localparam int DITH_W = ACC_W - ADDR_W;

  nco_pkg::nco_strobe_t strb;
  logic                 lfsrStep;
  logic [LFSR_W-1:0]    lfsrState;

  nco_ctrl #(.DITHER_EN(DITHER_EN)) u_ctrl (
    .en(en), .strb(strb), .lfsrStep(lfsrStep)
  );

  nco_lfsr #(.LFSR_W(LFSR_W), .SEED(SEED)) u_lfsr (
    .clk(clk), .rstN(rstN), .step(lfsrStep), .state(lfsrState)
  );

  nco_datapath #(
    .ACC_W(ACC_W), .ADDR_W(ADDR_W), .OUT_W(OUT_W), .DITH_W(DITH_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .phaseInc(phaseInc), .phaseShift(phaseShift),
    .ditherBits(lfsrState[DITH_W-1:0]),
    .phaseAddr(phaseAddr), .sawOut(sawOut), .squOut(squOut)
  );
endmodule

// File: rtl/nco_phase_gen_chk.sv
module nco_phase_gen_chk #(
  parameter int W         = 16,
  parameter bit DITHER_EN = 1'b0
) (
  input logic         clk,
  input logic         rstN,
  input logic         en,
  input logic [W-1:0] phaseAddr,
  input logic [W-1:0] sawOut,
  input logic [W-1:0] squOut,
  input logic [31:0]  lfsrState
);
  logic [W-1:0] gap;
  assign gap = phaseAddr - sawOut;

  AST_SQU_FOLLOWS_SAW: assert property (@(posedge clk) disable iff (!rstN)
    (squOut != '0) |-> (squOut == (sawOut[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}}))); // R5

  AST_ADDR_NO_DITHER: assert property (@(posedge clk) disable iff (!rstN)
    (DITHER_EN != 1'b0) || (gap == '0)); // R6

  AST_DITHER_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    gap <= 1); // R7

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    lfsrState != 32'h0); // R7

  AST_LFSR_SHIFTS: assert property (@(posedge clk) disable iff (!rstN)
    en |=> (lfsrState[31:1] == $past(lfsrState[30:0]))); // R7

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> ($stable(sawOut) && $stable(squOut) && $stable(phaseAddr) && $stable(lfsrState))); // R8
endmodule

bind nco_phase_gen nco_phase_gen_chk #(.W(OUT_W), .DITHER_EN(DITHER_EN)) u_chk (
  .clk(clk), .rstN(rstN), .en(en), .phaseAddr(phaseAddr),
  .sawOut(sawOut), .squOut(squOut), .lfsrState(lfsrState)
);

// File: tb/nco_phase_gen_test.sv
module nco_phase_gen_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        en = 1'b0;
  logic [31:0] phaseInc = '0;
  logic [31:0] phaseShift = '0;
  logic [15:0] phaseAddr, sawOut, squOut;
  logic [15:0] dAddr, dSaw, dSqu;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nco_phase_gen uut (
    .clk(clk), .rstN(rstN), .en(en), .phaseInc(phaseInc), .phaseShift(phaseShift),
    .phaseAddr(phaseAddr), .sawOut(sawOut), .squOut(squOut)
  );

  nco_phase_gen #(.DITHER_EN(1'b1), .SEED(32'hB5A3_0C17)) uutDith (
    .clk(clk), .rstN(rstN), .en(en), .phaseInc(phaseInc), .phaseShift(phaseShift),
    .phaseAddr(dAddr), .sawOut(dSaw), .squOut(dSqu)
  );

  typedef struct packed {
    logic [31:0] inc;
    logic [7:0]  edges;
    logic [15:0] saw;
    logic [15:0] squ;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{32'h4000_0000, 8'd5,  16'h4000, 16'h7FFF},
    '{32'h4000_0000, 8'd6,  16'h8000, 16'h8000},
    '{32'h4000_0000, 8'd7,  16'hC000, 16'h8000},
    '{32'h4000_0000, 8'd8,  16'h0000, 16'h7FFF},
    '{32'h0001_0000, 8'd14, 16'h000A, 16'h7FFF},
    '{32'hFFFF_0000, 8'd6,  16'hFFFE, 16'h8000},
    '{32'h1234_5678, 8'd5,  16'h1234, 16'h7FFF},
    '{32'h1234_5678, 8'd6,  16'h2468, 16'h7FFF},
    '{32'h8000_0000, 8'd5,  16'h8000, 16'h8000},
    '{32'h8000_0000, 8'd6,  16'h0000, 16'h7FFF}
  };

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%04h expected 0x%04h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic startRun(logic [31:0] inc);
    @(negedge clk);
    rstN = 1'b0;
    en = 1'b1;
    phaseShift = '0;
    phaseInc = inc;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // one enabled step, returning the sawtooth difference
  task automatic stepDiff(output logic [15:0] d);
    logic [15:0] prev;
    prev = sawOut;
    step();
    d = sawOut - prev;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [15:0] gap;
    int carries;

    // R3: reset state
    #3;
    check("R3", "reset phaseAddr", phaseAddr, 16'h0000);
    check("R3", "reset sawOut", sawOut, 16'h0000);
    check("R3", "reset squOut", squOut, 16'h0000);

    // R1, R5, R6: vector table from reset
    for (int i = 0; i < NVEC; i++) begin
      startRun(VECS[i].inc);
      repeat (int'(VECS[i].edges)) step();
      check("R1", $sformatf("vec%0d sawOut", i), sawOut, VECS[i].saw);
      check("R5", $sformatf("vec%0d squOut", i), squOut, VECS[i].squ);
      check("R6", $sformatf("vec%0d phaseAddr", i), phaseAddr, VECS[i].saw);
    end

    // R2: first output appears on the fifth edge
    startRun(32'h4000_0000);
    repeat (4) step();
    check("R2", "sawOut after edge 4", sawOut, 16'h0000);
    step();
    check("R2", "sawOut after edge 5", sawOut, 16'h4000);

    // R2: increment change latency
    startRun(32'h0100_0000);
    repeat (8) step();
    phaseInc = 32'h0300_0000;
    repeat (3) stepDiff(d);
    stepDiff(d);
    check("R2", "step 4 edges after change", d, 16'h0100);
    stepDiff(d);
    check("R2", "step 5 edges after change", d, 16'h0300);

    // R4: one-shot phase shift of 45 degrees
    startRun(32'h1000_0000);
    repeat (8) step();
    phaseShift = 32'h2000_0000;
    stepDiff(d);
    phaseShift = '0;
    repeat (2) stepDiff(d);
    stepDiff(d);
    check("R4", "step before shift lands", d, 16'h1000);
    stepDiff(d);
    check("R4", "step carrying shift", d, 16'h3000);
    stepDiff(d);
    check("R4", "step after shift", d, 16'h1000);

    // R8: stall freezes outputs and ignores a shift pulse
    startRun(32'h1000_0000);
    repeat (8) step();
    en = 1'b0;
    phaseShift = 32'h2000_0000;
    for (int k = 0; k < 4; k++) begin
      stepDiff(d);
      check("R8", $sformatf("stall cycle %0d saw step", k), d, 16'h0000);
    end
    phaseShift = '0;
    en = 1'b1;
    for (int k = 0; k < 6; k++) begin
      stepDiff(d);
      check("R8", $sformatf("resume step %0d", k), d, 16'h1000);
    end

    // R3: asynchronous reset mid-run
    @(negedge clk);
    #1 rstN = 1'b0;
    #1;
    check("R3", "async reset sawOut", sawOut, 16'h0000);
    check("R3", "async reset squOut", squOut, 16'h0000);
    check("R3", "async reset phaseAddr", phaseAddr, 16'h0000);

    // R7: dithered copy
    startRun(32'h0000_8000);
    repeat (6) step();
    carries = 0;
    for (int k = 0; k < 200; k++) begin
      step();
      gap = dAddr - dSaw;
      if (gap == 16'h0001) carries++;
      check("R7", "dither gap within 0..1", {15'b0, (gap <= 16'h0001)}, 16'h0001);
      check("R7", "dithered saw matches clean saw", dSaw, sawOut);
      check("R7", "dithered square matches clean square", dSqu, squOut);
    end
    check("R7", "some dither carries", {15'b0, (carries > 0)}, 16'h0001);
    check("R7", "not every sample carries", {15'b0, (carries < 200)}, 16'h0001);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule